// File: doc/BRIEF.md
# Host adapter control register

This block is a single 16-bit control and status word that a host processor reads and writes to configure a network adapter and to run a pseudo-DMA handshake in software. Each bit follows its own access rule. Some bits mirror live pins. One bit can only be set. Two bits accept writes only while the adapter is held in reset. Other bits are status fed by the adapter's DMA logic. Two of the bits load their reset values from strap pins.

The host reaches the word through a single-cycle port. A select, a write enable and an address qualify each access, and read data comes back on a registered bus one cycle after the read. The block decodes the three configuration pins into a network-type code. It also reports the pseudo-DMA handshake state, and raises an interrupt while a request is pending. Once pseudo-DMA is enabled, the hold-acknowledge seen by the DMA logic comes from the software bit and no longer from the hardware pin.

Top module: `host_adapter_ctl`

## Requirements
- R1: While rst_n is low at a clock edge, the state is set as follows. Bit 8 (adapter reset) becomes 1. Bits 4, 6 and 7 become 0. Bit 9 loads the bootstrap pin and bit 10 loads the parity pin, so the last levels sampled during reset are kept. host_rdata becomes 0.
- R2: Bits 2:0 always read the live cfg_pin levels, with bit 0 taken from cfg_pin[0]. Host writes to these bits are ignored.
- R3: Bit 3 and bits 15:11 always read 0, and host writes to them are ignored.
- R4: net_type_o decodes {cfg_pin[2],cfg_pin[1],cfg_pin[0]} as follows: 3'b110 gives 1 (16 Mbps token ring), 3'b101 gives 2 (Ethernet), 3'b111 gives 3 (4 Mbps token ring), and 3'b100 or any pattern with cfg_pin[2]=0 gives 0 (reserved).
- R5: Bit 7 (pseudo-DMA enable) is set-only. Writing 1 sets it, writing 0 has no effect, and only reset clears it.
- R6: Bits 9 and 10 accept a host write only if bit 8 was 1 before that write. A single write that clears bit 8 and changes bit 9 or bit 10 still updates them. Writes made while bit 8 is 0 leave bits 9 and 10 unchanged.
- R7: Bit 8 is read/write and drives adapter_reset_o. boot_sel_o follows bit 9 and parity_en_o follows bit 10.
- R8: Bit 4 (software hold-acknowledge) takes a written 1 only if bit 7 was already 1 before the write, so a single write that sets both bits leaves bit 4 at 0. Writing 0 to bit 4 clears it.
- R9: Bit 6 (request) cannot be written by the host. It sets one cycle after dma_req_i is high while bit 7 is 1, and clears one cycle after dma_done_i is high. If both inputs are high in the same cycle, the set wins. While bit 7 is 0, dma_req_i is ignored.
- R10: pdma_state_o reports the handshake: 0 while bit 7 is 0, 1 for idle (bit 4 is 0 and bit 6 is 0), 2 for request pending (bit 4 is 0 and bit 6 is 1), and 3 for transfer in progress (bit 4 is 1). pdma_irq_o is high exactly when the state is 2.
- R11: hold_ack_o equals hw_hold_ack_i while bit 7 is 0. While bit 7 is 1, hold_ack_o equals bit 4 and the hardware pin is ignored.
- R12: Bit 5 always reads the live dma_dir_i level (0 means host to adapter, 1 means adapter to host). Host writes to bit 5 are ignored.
- R13: A read (host_sel=1, host_we=0) at address REG_ADDR puts the register image on host_rdata after the next clock edge. A read at any other address returns 0. Without a read, host_rdata holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, also the strap sampling window |
| host_sel | input | 1 | Host access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Host word address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Registered read data |
| cfg_pin | input | 3 | Configuration test pins |
| boot_strap | input | 1 | Bootstrap strap pin |
| parity_strap | input | 1 | Parity-enable strap pin |
| dma_req_i | input | 1 | Pseudo-DMA request from adapter logic |
| dma_done_i | input | 1 | Pseudo-DMA transfer complete |
| dma_dir_i | input | 1 | Current DMA direction |
| hw_hold_ack_i | input | 1 | Hardware hold-acknowledge pin |
| adapter_reset_o | output | 1 | Adapter reset control |
| boot_sel_o | output | 1 | Boot selection bit |
| parity_en_o | output | 1 | Parity enable bit |
| net_type_o | output | 2 | Decoded network type |
| pdma_state_o | output | 2 | Handshake state |
| pdma_irq_o | output | 1 | Request-pending interrupt |
| hold_ack_o | output | 1 | Effective hold-acknowledge |

## Verification
Two pairs of events can land on the same clock edge. In the first pair, the adapter raises a request and reports completion in the same cycle. The bench drives dma_req_i and dma_done_i together and expects the request bit to stay set, with the state reading request pending. In the second pair, one host write both opens a gate and uses it. The bench writes enable and acknowledge in one access, and clears adapter reset while rewriting the strap bits in another. Each such write is judged against the pre-write value of the gating bit.

// File: rtl/hactl_pkg.sv
package hactl_pkg;

   // Bit positions inside the register image
   localparam int CFG_PINS     = 3;
   localparam int POS_CFG_LO   = 0;
   localparam int POS_RSVD     = 3;
   localparam int POS_ACK      = 4;
   localparam int POS_DIR      = 5;
   localparam int POS_REQ      = 6;
   localparam int POS_EN       = 7;
   localparam int POS_ARST     = 8;
   localparam int POS_BOOT     = 9;
   localparam int POS_PAR      = 10;
   localparam int TOP_USED_BIT = POS_PAR;

   // Host-written storage cells
   localparam int N_CELLS   = 4;
   localparam int CELL_EN   = 0;
   localparam int CELL_ARST = 1;
   localparam int CELL_BOOT = 2;
   localparam int CELL_PAR  = 3;

   typedef enum logic [1:0] {
      CK_RW   = 2'd0,
      CK_SET1 = 2'd1,
      CK_WIN  = 2'd2
   } cell_kind_e;

   typedef enum logic [1:0] {
      NET_RSVD = 2'd0,
      NET_TR16 = 2'd1,
      NET_ETH  = 2'd2,
      NET_TR4  = 2'd3
   } net_kind_e;

   typedef enum logic [1:0] {
      PD_OFF  = 2'd0,
      PD_IDLE = 2'd1,
      PD_PEND = 2'd2,
      PD_BUSY = 2'd3
   } pdma_state_e;

   function automatic int cell_pos(input int idx);
      case (idx)
         CELL_EN:   return POS_EN;
         CELL_ARST: return POS_ARST;
         CELL_BOOT: return POS_BOOT;
         default:   return POS_PAR;
      endcase
   endfunction

   function automatic cell_kind_e cell_kind(input int idx);
      case (idx)
         CELL_EN:   return CK_SET1;
         CELL_ARST: return CK_RW;
         default:   return CK_WIN;
      endcase
   endfunction

endpackage

// File: rtl/hactl_cell.sv
module hactl_cell #(
   parameter hactl_pkg::cell_kind_e KIND = hactl_pkg::CK_RW
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rst_val,
   input  logic wr_en,
   input  logic wr_val,
   input  logic win_open,
   output logic q
);
   import hactl_pkg::*;

   logic unused_win;
   assign unused_win = win_open;

   generate
      if (KIND == CK_RW) begin : g_rw
         always_ff @(posedge clk) begin
            if (!rst_n)     q <= rst_val;
            else if (wr_en) q <= wr_val;
         end
      end else if (KIND == CK_SET1) begin : g_set1
         always_ff @(posedge clk) begin
            if (!rst_n)               q <= rst_val;
            else if (wr_en && wr_val) q <= 1'b1;
         end
      end else begin : g_win
         always_ff @(posedge clk) begin
            if (!rst_n)                 q <= rst_val;
            else if (wr_en && win_open) q <= wr_val;
         end
      end
   endgenerate

endmodule

// File: rtl/hactl_pins.sv
module hactl_pins (
   input  logic [hactl_pkg::CFG_PINS-1:0] cfg_pin,
   output hactl_pkg::net_kind_e           net_type
);
   import hactl_pkg::*;

   always_comb begin
      if (!cfg_pin[2]) begin
         net_type = NET_RSVD;
      end else begin
         case (cfg_pin[1:0])
            2'b10:   net_type = NET_TR16;
            2'b01:   net_type = NET_ETH;
            2'b11:   net_type = NET_TR4;
            default: net_type = NET_RSVD;
         endcase
      end
   end

endmodule

// File: rtl/hactl_pdma.sv
module hactl_pdma (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic                    wr_en,
   input  logic                    wr_ack,
   input  logic                    req_set,
   input  logic                    req_clr,
   input  logic                    hw_hold_ack,
   output logic                    sw_ack,
   output logic                    req,
   output hactl_pkg::pdma_state_e  state,
   output logic                    irq,
   output logic                    hold_ack
);
   import hactl_pkg::*;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sw_ack <= 1'b0;
      end else if (wr_en) begin
         if (!wr_ack)  sw_ack <= 1'b0;
         else if (en)  sw_ack <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)              req <= 1'b0;
      else if (req_set && en)  req <= 1'b1;
      else if (req_clr)        req <= 1'b0;
   end

   always_comb begin
      if (!en)         state = PD_OFF;
      else if (sw_ack) state = PD_BUSY;
      else if (req)    state = PD_PEND;
      else             state = PD_IDLE;
   end

   assign irq      = (state == PD_PEND);
   assign hold_ack = en ? sw_ack : hw_hold_ack;

endmodule

// File: rtl/hactl_port.sv
module hactl_port #(
   parameter int                ADDR_W   = 4,
   parameter int                DATA_W   = 16,
   parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] image,
   output logic              wr_hit,
   output logic [DATA_W-1:0] rdata
);
   logic addr_hit;
   logic rd_any;

   assign addr_hit = (addr == REG_ADDR);
   assign wr_hit   = sel && we && addr_hit;
   assign rd_any   = sel && !we;

   always_ff @(posedge clk) begin
      if (!rst_n)      rdata <= '0;
      else if (rd_any) rdata <= addr_hit ? image : '0;
   end

endmodule

// File: rtl/host_adapter_ctl.sv
module host_adapter_ctl #(
   parameter int                ADDR_W   = 4,
   parameter int                DATA_W   = 16,
   parameter logic [ADDR_W-1:0] REG_ADDR = 4'h2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_sel,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic [2:0]        cfg_pin,
   input  logic              boot_strap,
   input  logic              parity_strap,
   input  logic              dma_req_i,
   input  logic              dma_done_i,
   input  logic              dma_dir_i,
   input  logic              hw_hold_ack_i,
   output logic              adapter_reset_o,
   output logic              boot_sel_o,
   output logic              parity_en_o,
   output logic [1:0]        net_type_o,
   output logic [1:0]        pdma_state_o,
   output logic              pdma_irq_o,
   output logic              hold_ack_o
);
   import hactl_pkg::*;

   localparam int MIN_W = TOP_USED_BIT + 1;

   generate
      if (DATA_W < MIN_W) begin : g_bad_width
         $error("host_adapter_ctl: DATA_W too small for the register layout");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("host_adapter_ctl: ADDR_W must be at least 1");
      end
   endgenerate

   logic                 wr_hit;
   logic [DATA_W-1:0]    image;
   logic [N_CELLS-1:0]   cell_q;
   logic [N_CELLS-1:0]   cell_rst;
   logic                 pdma_en;
   logic                 arst_q;
   logic                 sw_ack;
   logic                 req_q;
   net_kind_e            net_kind;
   pdma_state_e          pd_state;
   logic                 unused_wdata;

   assign unused_wdata = ^host_wdata;

   always_comb begin
      cell_rst            = '0;
      cell_rst[CELL_EN]   = 1'b0;
      cell_rst[CELL_ARST] = 1'b1;
      cell_rst[CELL_BOOT] = boot_strap;
      cell_rst[CELL_PAR]  = parity_strap;
   end

   assign pdma_en = cell_q[CELL_EN];
   assign arst_q  = cell_q[CELL_ARST];

   generate
      for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
         hactl_cell #(
            .KIND (cell_kind(g))
         ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .rst_val  (cell_rst[g]),
            .wr_en    (wr_hit),
            .wr_val   (host_wdata[cell_pos(g)]),
            .win_open (arst_q),
            .q        (cell_q[g])
         );
      end
   endgenerate

   hactl_pdma u_pdma (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (pdma_en),
      .wr_en       (wr_hit),
      .wr_ack      (host_wdata[POS_ACK]),
      .req_set     (dma_req_i),
      .req_clr     (dma_done_i),
      .hw_hold_ack (hw_hold_ack_i),
      .sw_ack      (sw_ack),
      .req         (req_q),
      .state       (pd_state),
      .irq         (pdma_irq_o),
      .hold_ack    (hold_ack_o)
   );

   hactl_pins u_pins (
      .cfg_pin  (cfg_pin),
      .net_type (net_kind)
   );

   always_comb begin
      image = '0;
      image[POS_CFG_LO +: CFG_PINS] = cfg_pin;
      image[POS_ACK]                = sw_ack;
      image[POS_DIR]                = dma_dir_i;
      image[POS_REQ]                = req_q;
      for (int i = 0; i < N_CELLS; i++) begin
         image[cell_pos(i)] = cell_q[i];
      end
   end

   hactl_port #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .REG_ADDR (REG_ADDR)
   ) u_port (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (host_sel),
      .we     (host_we),
      .addr   (host_addr),
      .image  (image),
      .wr_hit (wr_hit),
      .rdata  (host_rdata)
   );

   assign adapter_reset_o = arst_q;
   assign boot_sel_o      = cell_q[CELL_BOOT];
   assign parity_en_o     = cell_q[CELL_PAR];
   assign net_type_o      = net_kind;
   assign pdma_state_o    = pd_state;

endmodule

// File: rtl/host_adapter_ctl_chk.sv
module host_adapter_ctl_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_sel,
   input logic              host_we,
   input logic [DATA_W-1:0] host_rdata,
   input logic              pdma_en,
   input logic              sw_ack,
   input logic              req_q,
   input logic              arst_q,
   input logic              boot_q,
   input logic              par_q,
   input logic              dma_req_i,
   input logic              hold_ack_o
);
   // R3: reserved positions read back as zero
   a_r3_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
      host_rdata[3] == 1'b0 && host_rdata[DATA_W-1:11] == '0);

   // R5: once enabled, stays enabled until reset
   a_r5_set_only: assert property (@(posedge clk) disable iff (!rst_n)
      pdma_en |=> pdma_en);

   // R6: strap bits frozen while the adapter is out of reset
   a_r6_boot_locked: assert property (@(posedge clk) disable iff (!rst_n)
      !arst_q |=> $stable(boot_q));
   a_r6_par_locked: assert property (@(posedge clk) disable iff (!rst_n)
      !arst_q |=> $stable(par_q));

   // R8: acknowledge never set without enable
   a_r8_ack_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      !pdma_en |-> !sw_ack);

   // R9: a request seen with enable set is captured
   a_r9_req_captured: assert property (@(posedge clk) disable iff (!rst_n)
      pdma_en && dma_req_i |=> req_q);
   a_r9_req_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      !pdma_en |-> !req_q);

   // R11: hardware pin has no effect while pseudo-DMA is enabled
   a_r11_pin_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      pdma_en && $past(pdma_en) && $stable(sw_ack) |-> $stable(hold_ack_o));

   // R13: read data only moves on a read
   a_r13_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_sel && !host_we) |=> $stable(host_rdata));

endmodule

bind host_adapter_ctl host_adapter_ctl_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_sel   (host_sel),
   .host_we    (host_we),
   .host_rdata (host_rdata),
   .pdma_en    (pdma_en),
   .sw_ack     (sw_ack),
   .req_q      (req_q),
   .arst_q     (arst_q),
   .boot_q     (boot_sel_o),
   .par_q      (parity_en_o),
   .dma_req_i  (dma_req_i),
   .hold_ack_o (hold_ack_o)
);

// File: tb/host_adapter_ctl_test.sv
module host_adapter_ctl_test;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int             AW = 4;
   localparam int             DW = 16;
   localparam logic [AW-1:0]  RA = 4'h2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_sel = 1'b0;
   logic          host_we = 1'b0;
   logic [AW-1:0] host_addr = '0;
   logic [DW-1:0] host_wdata = '0;
   logic [DW-1:0] host_rdata;
   logic [2:0]    cfg_pin = 3'b110;
   logic          boot_strap = 1'b1;
   logic          parity_strap = 1'b0;
   logic          dma_req_i = 1'b0;
   logic          dma_done_i = 1'b0;
   logic          dma_dir_i = 1'b0;
   logic          hw_hold_ack_i = 1'b0;
   logic          adapter_reset_o, boot_sel_o, parity_en_o, pdma_irq_o, hold_ack_o;
   logic [1:0]    net_type_o, pdma_state_o;

   always #2 clk = ~clk;

   host_adapter_ctl #(.ADDR_W(AW), .DATA_W(DW), .REG_ADDR(RA)) uut (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_we(host_we),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .cfg_pin(cfg_pin), .boot_strap(boot_strap), .parity_strap(parity_strap),
      .dma_req_i(dma_req_i), .dma_done_i(dma_done_i), .dma_dir_i(dma_dir_i),
      .hw_hold_ack_i(hw_hold_ack_i), .adapter_reset_o(adapter_reset_o),
      .boot_sel_o(boot_sel_o), .parity_en_o(parity_en_o), .net_type_o(net_type_o),
      .pdma_state_o(pdma_state_o), .pdma_irq_o(pdma_irq_o), .hold_ack_o(hold_ack_o)
   );

   int n_vec = 0;
   int n_bad = 0;
   bit done_flag = 1'b0;

   // reference model of the stored bits
   logic m_en, m_ack, m_req, m_arst, m_boot, m_par;

   logic [DW-1:0] exp_q[$];
   string         tag_q[$];
   logic          rd_seen = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] model_img();
      logic [DW-1:0] v = '0;
      v[2:0] = cfg_pin;
      v[4]   = m_ack;
      v[5]   = dma_dir_i;
      v[6]   = m_req;
      v[7]   = m_en;
      v[8]   = m_arst;
      v[9]   = m_boot;
      v[10]  = m_par;
      return v;
   endfunction

   function automatic logic [1:0] model_state();
      if (!m_en)      return 2'd0;
      else if (m_ack) return 2'd3;
      else if (m_req) return 2'd2;
      else            return 2'd1;
   endfunction

   function automatic logic [1:0] model_net(input logic [2:0] p);
      case (p)
         3'b110:  return 2'd1;
         3'b101:  return 2'd2;
         3'b111:  return 2'd3;
         default: return 2'd0;
      endcase
   endfunction

   // scoreboard monitor
   always @(posedge clk) rd_seen <= rst_n && host_sel && !host_we;

   always @(negedge clk) begin
      if (rd_seen) begin
         if (exp_q.size() == 0) begin
            chk("R13 unexpected read", 32'd1, 32'd0);
         end else begin
            logic [DW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, 32'(host_rdata), 32'(e));
         end
      end
   end

   task automatic do_reset(input logic bs, input logic ps);
      @(negedge clk);
      rst_n = 1'b0;
      boot_strap = ~bs;
      parity_strap = ~ps;
      @(negedge clk);
      boot_strap = bs;
      parity_strap = ps;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      m_en = 0; m_ack = 0; m_req = 0; m_arst = 1; m_boot = bs; m_par = ps;
      #0.2;
   endtask

   task automatic wr(input logic [DW-1:0] d);
      @(negedge clk);
      host_sel = 1'b1; host_we = 1'b1; host_addr = RA; host_wdata = d;
      if (!d[4])     m_ack = 1'b0;
      else if (m_en) m_ack = 1'b1;
      if (m_arst) begin
         m_boot = d[9];
         m_par  = d[10];
      end
      m_en   = m_en | d[7];
      m_arst = d[8];
      @(negedge clk);
      host_sel = 1'b0; host_we = 1'b0;
      #0.2;
   endtask

   task automatic rd(input string tag, input logic [AW-1:0] a);
      @(negedge clk);
      host_sel = 1'b1; host_we = 1'b0; host_addr = a;
      exp_q.push_back((a == RA) ? model_img() : '0);
      tag_q.push_back(tag);
      @(negedge clk);
      host_sel = 1'b0;
      #0.2;
   endtask

   task automatic pulse(input logic rq, input logic dn);
      @(negedge clk);
      dma_req_i = rq; dma_done_i = dn;
      if (rq && m_en) m_req = 1'b1;
      else if (dn)    m_req = 1'b0;
      @(negedge clk);
      dma_req_i = 1'b0; dma_done_i = 1'b0;
      #0.2;
   endtask

   task automatic chk_pd(input string tag);
      chk({tag, " state"}, 32'(pdma_state_o), 32'(model_state()));
      chk({tag, " irq"}, 32'(pdma_irq_o), 32'(model_state() == 2'd2));
   endtask

   initial begin
      logic [DW-1:0] held;
      do_reset(1'b1, 1'b0);
      // R1: reset state
      chk("R1 rdata after reset", 32'(host_rdata), 32'd0);
      chk("R1 adapter_reset_o", 32'(adapter_reset_o), 32'd1);
      chk("R1 boot strap", 32'(boot_sel_o), 32'd1);
      chk("R1 parity strap", 32'(parity_en_o), 32'd0);
      rd("R1 image", RA);

      // R4 decode, all patterns; R2 live mirror
      for (int p = 0; p < 8; p++) begin
         @(negedge clk);
         cfg_pin = 3'(p);
         #0.2;
         chk("R4 net type", 32'(net_type_o), 32'(model_net(3'(p))));
      end
      cfg_pin = 3'b101;
      rd("R2 cfg mirror 101", RA);
      cfg_pin = 3'b011;
      rd("R2 cfg mirror 011", RA);

      // R11 pin passes while disabled; R9 request ignored while disabled
      hw_hold_ack_i = 1'b1;
      #0.2;
      chk("R11 pin pass-through", 32'(hold_ack_o), 32'd1);
      hw_hold_ack_i = 1'b0;
      #0.2;
      chk("R11 pin pass-through low", 32'(hold_ack_o), 32'd0);
      pulse(1'b1, 1'b0);
      chk_pd("R9 req ignored while off R10");
      rd("R9 req bit stays 0", RA);

      // R8 enable and ack in one write: ack stays 0; R2 R3 R12 writes ignored
      wr(16'hFFFF);
      rd("R8 R3 R2 R12 after all-ones write", RA);
      chk_pd("R10 idle");
      wr(16'h0190);
      chk_pd("R8 ack set R10 busy");
      chk("R11 hold from ack", 32'(hold_ack_o), 32'd1);
      hw_hold_ack_i = 1'b1;
      wr(16'h0180);
      chk("R11 pin ignored", 32'(hold_ack_o), 32'd0);
      chk_pd("R8 ack cleared R10");

      // R9 request set, set+done together, done
      pulse(1'b1, 1'b0);
      chk_pd("R9 req set R10 pend");
      pulse(1'b1, 1'b1);
      chk_pd("R9 set wins over done");
      rd("R9 req bit", RA);
      wr(16'h0190);
      chk_pd("R10 ack over req");
      wr(16'h0180);
      pulse(1'b0, 1'b1);
      chk_pd("R9 done clears");

      // R6/R7 strap window
      wr(16'h0600);
      chk("R7 adapter reset cleared", 32'(adapter_reset_o), 32'd0);
      chk("R6 boot via closing write", 32'(boot_sel_o), 32'd1);
      chk("R6 parity via closing write", 32'(parity_en_o), 32'd1);
      wr(16'h0000);
      chk("R6 boot locked", 32'(boot_sel_o), 32'd1);
      chk("R6 parity locked", 32'(parity_en_o), 32'd1);
      rd("R5 enable survives write 0", RA);
      wr(16'h0100);
      chk("R7 adapter reset set", 32'(adapter_reset_o), 32'd1);
      wr(16'h0000);
      chk("R6 window open clears boot", 32'(boot_sel_o), 32'd0);
      chk("R7 parity output", 32'(parity_en_o), 32'd0);

      // R12 direction mirror
      dma_dir_i = 1'b1;
      rd("R12 dir high", RA);
      dma_dir_i = 1'b0;
      rd("R12 dir low", RA);

      // R13 other address, hold without read
      rd("R13 other address", 4'h5);
      rd("R13 image", RA);
      held = host_rdata;
      wr(16'h0100);
      repeat (3) @(negedge clk);
      #0.2;
      chk("R13 hold without read", 32'(host_rdata), 32'(held));

      // R1 second reset with other straps; R5 reset clears enable
      do_reset(1'b0, 1'b1);
      chk("R1 boot strap second", 32'(boot_sel_o), 32'd0);
      chk("R1 parity strap second", 32'(parity_en_o), 32'd1);
      rd("R1 R5 image after second reset", RA);
      chk_pd("R5 enable cleared by reset");

      repeat (2) @(negedge clk);
      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done_flag) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule